// File: doc/BRIEF.md
# Truth-Table Bitwise Logic Unit

This block applies any of the sixteen two-input Boolean functions across two operand words, bit by bit. The 4-bit function code is not decoded. It is the truth table of the operation. In every bit lane the operand pair {B[i], A[i]} works as a 2-bit index, and that index picks one bit of the code. Every lane reads the same code, and no lane depends on any other lane. The combinational result is available on its own port in the same cycle as its inputs.

For use inside a datapath, the result passes through an output stage that uses valid/ready handshakes. The stage holds the result, the function code that produced it, and a zero flag. It accepts a beat when `in_valid` and `in_ready` are both high on a rising clock edge, and it presents that beat on the following cycle. While `out_valid` is high and `out_ready` is low, the stage holds the beat and drops `in_ready`. If `out_ready` is high, a held beat drains and a new beat is accepted on the same edge, so throughput stays at one beat per cycle. Setting the parameter `PIPE` to 0 removes the register and connects the handshake straight through.

Top module: `tt_logic_unit`

## Requirements
- R1: For every lane i, `comb_result[i]` equals `func[{op_b[i], op_a[i]}]`, so code bit 0 is selected when both operand bits are 0 and code bit 3 when both are 1. The output settles in the same cycle, with no clock involved.
- R2: Code 0x0 drives every result bit to 0, and code 0xF drives every result bit to 1.
- R3: Code 0xA returns A, 0xC returns B, 0x5 returns NOT A, and 0x3 returns NOT B.
- R4: Code 0x8 returns A AND B, 0xE returns A OR B, 0x6 returns A XOR B, and 0x9 returns A XNOR B.
- R5: Code 0x7 returns NAND and 0x1 returns NOR. Code 0x4 returns (NOT A) AND B, 0x2 returns A AND (NOT B), 0xD returns (NOT A) OR B, and 0xB returns A OR (NOT B).
- R6: All lanes use the single function code, and each lane's output depends only on that lane's own operand bits.
- R7: A beat accepted on a clock edge appears on the next cycle with `out_valid` high. It carries its result on `out_result` and its code on `out_func`, and beats leave in the order they were accepted.
- R8: `out_zero` is 1 exactly when the captured `out_result` is all zeros.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_result`, `out_func` and `out_zero` hold their values.
- R10: `in_ready` is high exactly when the stage is empty or `out_ready` is high.
- R11: A synchronous active-high `rst` clears `out_valid` on the next edge and discards any held beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and code are valid |
| in_ready | output | 1 | Stage can accept a beat |
| op_a | input | WIDTH | Operand A |
| op_b | input | WIDTH | Operand B |
| func | input | 4 | Truth-table function code |
| comb_result | output | WIDTH | Unregistered result |
| out_valid | output | 1 | Registered beat is valid |
| out_ready | input | 1 | Consumer accepts the beat |
| out_result | output | WIDTH | Registered result |
| out_func | output | 4 | Code of the registered beat |
| out_zero | output | 1 | Registered result is all zeros |

## Verification
Two functions of the output stage can occur on the same clock edge: a held beat drains and a new beat is captured. A long stream provokes this. On each cycle the stream sets `in_valid` and `out_ready` at random, and the codes and operands come from a corner set (all zeros, all ones, alternating patterns) mixed with random values. An order-keeping scoreboard judges every drained beat against a reference table that the bench builds from the listed code meanings. The bench also checks that a stalled beat stays unchanged and that `in_ready` follows the rule in R10 on every cycle.

// File: rtl/tt_logic_pkg.sv
package tt_logic_pkg;
  localparam int FUNC_W = 4;
  localparam int SEL_W  = 2;
  typedef logic [FUNC_W-1:0] tt_func_t;

  localparam tt_func_t FN_CLEAR = 4'h0;
  localparam tt_func_t FN_SET   = 4'hF;
  localparam tt_func_t FN_PASSA = 4'hA;
  localparam tt_func_t FN_PASSB = 4'hC;
  localparam tt_func_t FN_AND   = 4'h8;
  localparam tt_func_t FN_OR    = 4'hE;
  localparam tt_func_t FN_XOR   = 4'h6;
  localparam tt_func_t FN_NAND  = 4'h7;
endpackage

// File: rtl/tt_lane_mux.sv
module tt_lane_mux
  import tt_logic_pkg::*;
(
  input  tt_func_t code,
  input  logic     bit_a,
  input  logic     bit_b,
  output logic     q
);
  logic [SEL_W-1:0] sel;
  assign sel = {bit_b, bit_a};

  always_comb begin
    unique case (sel)
      2'b00:   q = code[0];
      2'b01:   q = code[1];
      2'b10:   q = code[2];
      default: q = code[3];
    endcase
  end
endmodule

// File: rtl/tt_lane_array.sv
module tt_lane_array
  import tt_logic_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  tt_func_t         code,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_lane
    tt_lane_mux u_mux (
      .code  (code),
      .bit_a (a[i]),
      .bit_b (b[i]),
      .q     (q[i])
    );
  end
endmodule

// File: rtl/tt_out_stage.sv
module tt_out_stage #(
  parameter int PAY_W = 13,
  parameter bit PIPE  = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PAY_W-1:0] in_pay,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PAY_W-1:0] out_pay
);
  if (PIPE) begin : g_reg
    logic             v_q;
    logic [PAY_W-1:0] p_q;

    assign in_ready = !v_q || out_ready;

    always_ff @(posedge clk) begin
      if (rst)           v_q <= 1'b0;
      else if (in_ready) v_q <= in_valid;
      if (in_valid && in_ready) p_q <= in_pay;
    end

    assign out_valid = v_q;
    assign out_pay   = p_q;
  end else begin : g_wire
    logic unused_clk;
    assign unused_clk = clk ^ rst;
    assign in_ready   = out_ready;
    assign out_valid  = in_valid;
    assign out_pay    = in_pay;
  end
endmodule

// File: rtl/tt_logic_unit.sv
module tt_logic_unit
  import tt_logic_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter bit PIPE  = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [3:0]       func,
  output logic [WIDTH-1:0] comb_result,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_result,
  output logic [3:0]       out_func,
  output logic             out_zero
);
  localparam int PAY_W = WIDTH + FUNC_W + 1;

  logic [WIDTH-1:0] lane_q;
  logic             lane_zero;
  logic [PAY_W-1:0] pay_in, pay_out;

  tt_lane_array #(.WIDTH(WIDTH)) u_lanes (
    .code (func),
    .a    (op_a),
    .b    (op_b),
    .q    (lane_q)
  );

  assign lane_zero   = ~|lane_q;
  assign comb_result = lane_q;
  assign pay_in      = {lane_zero, func, lane_q};

  tt_out_stage #(.PAY_W(PAY_W), .PIPE(PIPE)) u_stage (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_pay    (pay_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_pay   (pay_out)
  );

  assign out_result = pay_out[WIDTH-1:0];
  assign out_func   = pay_out[WIDTH+FUNC_W-1:WIDTH];
  assign out_zero   = pay_out[PAY_W-1];
endmodule

// File: rtl/tt_logic_unit_chk.sv
module tt_logic_unit_chk #(
  parameter int WIDTH = 8,
  parameter bit PIPE  = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic [3:0]       func,
  input logic [WIDTH-1:0] comb_result,
  input logic             out_valid,
  input logic             out_ready,
  input logic [WIDTH-1:0] out_result,
  input logic [3:0]       out_func,
  input logic             out_zero
);
  p_clear_r2: assert property (@(posedge clk) disable iff (rst)
    func == 4'h0 |-> comb_result == '0);
  p_set_r2: assert property (@(posedge clk) disable iff (rst)
    func == 4'hF |-> comb_result == '1);
  p_pass_r3: assert property (@(posedge clk) disable iff (rst)
    func == 4'hA |-> comb_result == op_a);
  p_xor_r4: assert property (@(posedge clk) disable iff (rst)
    func == 4'h6 |-> comb_result == (op_a ^ op_b));
  p_nand_r5: assert property (@(posedge clk) disable iff (rst)
    func == 4'h7 |-> comb_result == ~(op_a & op_b));

  if (PIPE) begin : g_pipe
    p_capture_r7: assert property (@(posedge clk) disable iff (rst)
      in_valid && in_ready |=> out_valid && out_func == $past(func)
                              && out_result == $past(comb_result));
    p_zero_r8: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> out_zero == (out_result == '0));
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |=> out_valid && $stable(out_result)
                                  && $stable(out_func) && $stable(out_zero));
    p_ready_r10: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |-> !in_ready);
    p_reset_r11: assert property (@(posedge clk)
      rst |=> !out_valid);
  end
endmodule

bind tt_logic_unit tt_logic_unit_chk #(.WIDTH(WIDTH), .PIPE(PIPE)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .op_a(op_a), .op_b(op_b), .func(func), .comb_result(comb_result),
  .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
  .out_func(out_func), .out_zero(out_zero)
);

// File: tb/tt_logic_unit_tb_top.sv
`timescale 1ns/1ps
module tt_logic_unit_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic [3:0]   func = '0;
  logic [W-1:0] comb_result;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [W-1:0] out_result;
  logic [3:0]   out_func;
  logic         out_zero;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  tt_logic_unit #(.WIDTH(W), .PIPE(1'b1)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .func(func), .comb_result(comb_result),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_func(out_func), .out_zero(out_zero)
  );

  function automatic logic [W-1:0] ref_op(input logic [3:0] f,
                                          input logic [W-1:0] a,
                                          input logic [W-1:0] b);
    case (f)
      4'h0: return '0;
      4'h1: return ~(a | b);
      4'h2: return a & ~b;
      4'h3: return ~b;
      4'h4: return ~a & b;
      4'h5: return ~a;
      4'h6: return a ^ b;
      4'h7: return ~(a & b);
      4'h8: return a & b;
      4'h9: return ~(a ^ b);
      4'hA: return a;
      4'hB: return a | ~b;
      4'hC: return b;
      4'hD: return ~a | b;
      4'hE: return a | b;
      default: return '1;
    endcase
  endfunction

  function automatic string code_tag(input logic [3:0] f);
    case (f)
      4'h0, 4'hF: return "R2";
      4'hA, 4'hC, 4'h5, 4'h3: return "R3";
      4'h8, 4'hE, 4'h6, 4'h9: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] pick_op(input int sel);
    case (sel % 6)
      0: return '0;
      1: return '1;
      2: return 8'hAA;
      3: return 8'h55;
      default: return W'($urandom);
    endcase
  endfunction

  logic [W-1:0] exp_res_q [$];
  logic [3:0]   exp_fn_q  [$];

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [W-1:0] hold_res;
    logic [3:0]   hold_fn;
    bit           was_stalled;
    int           beats;

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R11 reset", W'(out_valid), '0);
    rst = 1'b0;

    // Combinational sweep: every code against corner and random operands
    for (int f = 0; f < 16; f++) begin
      for (int k = 0; k < 48; k++) begin
        func = 4'(f);
        op_a = pick_op(k);
        op_b = pick_op(k / 6 + k);
        #1;
        chk(comb_result == ref_op(func, op_a, op_b),
            {"R1 ", code_tag(func)}, comb_result, ref_op(func, op_a, op_b));
      end
    end

    // Lane independence: distinct operand bits per lane, one shared code
    func = 4'h6; op_a = 8'hF0; op_b = 8'hCC; #1;
    chk(comb_result == 8'h3C, "R6 xor lanes", comb_result, 8'h3C);
    func = 4'h4; op_a = 8'hA5; op_b = 8'h3C; #1;
    chk(comb_result == 8'h18, "R6 nota_and_b lanes", comb_result, 8'h18);
    func = 4'h2; op_a = 8'h0F; op_b = 8'h33; #1;
    chk(comb_result == 8'h0C, "R6 a_and_notb lanes", comb_result, 8'h0C);

    // Single-beat latency
    @(negedge clk);
    out_ready = 1'b1; in_valid = 1'b1; func = 4'h8; op_a = 8'hF3; op_b = 8'h3F;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && out_result == 8'h33 && out_func == 4'h8,
        "R7 one-cycle latency", out_result, 8'h33);
    chk(out_zero == 1'b0, "R8 nonzero flag", W'(out_zero), '0);
    @(negedge clk);
    chk(out_valid == 1'b0, "R7 drained", W'(out_valid), '0);

    // Zero-result beat
    in_valid = 1'b1; func = 4'h0; op_a = 8'h5A;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && out_zero == 1'b1, "R8 zero flag", W'(out_zero), 1);
    @(negedge clk);

    // Random stream with back-pressure; concurrent drain and capture
    was_stalled = 1'b0;
    beats = 0;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      @(negedge clk);
      if (was_stalled) begin
        chk(out_valid && out_result == hold_res && out_func == hold_fn,
            "R9 stall hold", out_result, hold_res);
      end
      in_valid  = ($urandom % 4) != 0;
      out_ready = ($urandom % 3) != 0;
      func = 4'($urandom);
      op_a = pick_op(int'($urandom % 6));
      op_b = pick_op(int'($urandom % 6));
      #1;
      chk(in_ready == (!out_valid || out_ready), "R10 ready rule",
          W'(in_ready), W'(!out_valid || out_ready));
      if (out_valid && out_ready) begin
        if (exp_res_q.size() == 0) begin
          chk(1'b0, "R7 unexpected beat", out_result, '0);
        end else begin
          logic [W-1:0] er;
          logic [3:0]   ef;
          er = exp_res_q.pop_front();
          ef = exp_fn_q.pop_front();
          chk(out_result == er && out_func == ef, "R7 stream order",
              out_result, er);
          chk(out_zero == (er == '0), "R8 stream zero", W'(out_zero),
              W'(er == '0));
          beats++;
        end
      end
      if (in_valid && in_ready) begin
        exp_res_q.push_back(ref_op(func, op_a, op_b));
        exp_fn_q.push_back(func);
      end
      was_stalled = out_valid && !out_ready;
      hold_res = out_result;
      hold_fn  = out_func;
    end
    chk(beats > 100, "R7 beat count", W'(beats), W'(100));

    // Reset while a beat is held
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; func = 4'hF;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R9 held before reset", W'(out_valid), 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(out_valid == 1'b0, "R11 reset drops beat", W'(out_valid), '0);
    chk(in_ready == 1'b1, "R10 empty ready", W'(in_ready), 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule